// File: doc/BRIEF.md
# Scanline Counter with Line Compare

This block keeps track of which scanline a display raster is on. An internal dot counter consumes a dot tick from the pixel clock domain and, after a full line's worth of ticks, steps an 8-bit line counter. The line counter runs through 154 lines per frame, numbered 0 to 153, and then returns to 0.

Software loads a line compare register through a simple write port. The compare happens only when the line counter has just stepped. When the new line number equals the register, the block raises a coincidence flag in its status output. On that same step it also issues a one-cycle status interrupt request. The flag then stays as it is until the next step. The status port shows the coincidence flag and the current line number. Both are registered.

Top module: `scanline_counter`

## Requirements
- R1: Synchronous active-high reset clears the line number, the partial dot count, the compare register, the coincidence flag and the interrupt request.
- R2: The line number steps by one after every 456 dot ticks. Clock cycles without a dot tick do not count, and a line that has only partly elapsed does not step.
- R3: After line 153 the line number returns to 0. The line number never exceeds 153.
- R4: After each step, the new line number is compared with the compare register. The coincidence flag becomes 1 on equality and 0 otherwise. It changes on the clock edge after the edge that changed the line number.
- R5: Between steps the coincidence flag holds its value. A set flag clears on the first later step whose line does not match.
- R6: The interrupt request is high for exactly one cycle, in the same cycle the coincidence flag is updated by a matching step. It is never raised in any other cycle.
- R7: A write to the compare register has no effect on the coincidence flag or the interrupt request until the next step, even when the written value equals the current line.
- R8: A compare value above 153 never produces a coincidence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dot_tick | input | 1 | One dot has elapsed in this cycle |
| cmp_we | input | 1 | Write strobe for the line compare register |
| cmp_wdata | input | 8 | Value for the line compare register |
| stat_match | output | 1 | Coincidence flag |
| stat_line | output | 8 | Current line number |
| irq_stat | output | 1 | Status interrupt request, one-cycle pulse |

## Verification
A new line number appears on the rising edge that takes in the 456th dot tick of a line. The coincidence flag and the interrupt pulse follow one edge later, and the pulse is gone one edge after that. The bench drives and samples only at falling edges, so each check lands in a known cycle. It reads the line at the first falling edge after the final tick and expects the flag to still hold its previous value there. It reads the flag and pulse at the next falling edge, and confirms the pulse is low at the one after that. The reset, compare-write and partial-line checks hold the inputs for several cycles before sampling, which shows that the state is not drifting.

// File: rtl/scanline_pkg.sv
package scanline_pkg;
  localparam int DEF_DOTS_PER_LINE   = 456;
  localparam int DEF_LINES_PER_FRAME = 154;
  localparam int DEF_LINE_W          = 8;
endpackage

// File: rtl/scan_dot_counter.sv
module scan_dot_counter #(
  parameter int DOTS_PER_LINE = 456
) (
  input  logic clk,
  input  logic rst,
  input  logic dot_tick,
  output logic line_done
);
  localparam int DOT_W = $clog2(DOTS_PER_LINE);
  localparam logic [DOT_W-1:0] DOT_LAST = DOT_W'(DOTS_PER_LINE - 1);

  logic [DOT_W-1:0] dot_q;

  assign line_done = dot_tick && (dot_q == DOT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      dot_q <= '0;
    end else if (dot_tick) begin
      dot_q <= (dot_q == DOT_LAST) ? '0 : dot_q + 1'b1;
    end
  end

  // R2: only dot ticks move the count
  assert_dot_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !dot_tick |=> $stable(dot_q));
  assert_dot_range_R2: assert property (@(posedge clk) disable iff (rst)
    dot_q <= DOT_LAST);
endmodule

// File: rtl/scan_line_counter.sv
module scan_line_counter #(
  parameter int LINES_PER_FRAME = 154,
  parameter int LINE_W          = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_done,
  output logic [LINE_W-1:0] line_q,
  output logic              adv_q
);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES_PER_FRAME - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      adv_q  <= 1'b0;
    end else begin
      adv_q <= line_done;
      if (line_done) begin
        line_q <= (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
      end
    end
  end

  // R3: line number stays inside the frame
  assert_line_range_R3: assert property (@(posedge clk) disable iff (rst)
    line_q <= LINE_LAST);
  // R2: line holds unless a line just completed
  assert_line_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !line_done |=> $stable(line_q));
  // R2: the step strobe follows every line change
  assert_adv_follows_R2: assert property (@(posedge clk) disable iff (rst)
    line_done |=> adv_q);
endmodule

// File: rtl/scan_line_compare.sv
module scan_line_compare #(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_we,
  input  logic [LINE_W-1:0] cmp_wdata,
  input  logic [LINE_W-1:0] line,
  input  logic              adv,
  output logic              match_q,
  output logic              irq_q
);
  logic [LINE_W-1:0] cmp_q;
  logic              hit;

  assign hit = (line == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
    end else if (cmp_we) begin
      cmp_q <= cmp_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= adv && hit;
      if (adv) begin
        match_q <= hit;
      end
    end
  end

  // R7 / R5: flag only moves after a step
  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(match_q));
  // R6: request is a single-cycle pulse
  assert_irq_single_R6: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  // R6: request only alongside a set flag
  assert_irq_flag_R6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> match_q);
  // R6: no request without a step in the prior cycle
  assert_irq_step_R6: assert property (@(posedge clk) disable iff (rst)
    !adv |=> !irq_q);
endmodule

// File: rtl/scanline_counter.sv
module scanline_counter
  import scanline_pkg::*;
#(
  parameter int DOTS_PER_LINE   = DEF_DOTS_PER_LINE,
  parameter int LINES_PER_FRAME = DEF_LINES_PER_FRAME,
  parameter int LINE_W          = DEF_LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dot_tick,
  input  logic              cmp_we,
  input  logic [LINE_W-1:0] cmp_wdata,
  output logic              stat_match,
  output logic [LINE_W-1:0] stat_line,
  output logic              irq_stat
);
  logic              line_done;
  logic              adv;
  logic [LINE_W-1:0] line;

  scan_dot_counter #(.DOTS_PER_LINE(DOTS_PER_LINE)) u_dot (
    .clk(clk), .rst(rst), .dot_tick(dot_tick), .line_done(line_done)
  );

  scan_line_counter #(.LINES_PER_FRAME(LINES_PER_FRAME), .LINE_W(LINE_W)) u_line (
    .clk(clk), .rst(rst), .line_done(line_done), .line_q(line), .adv_q(adv)
  );

  scan_line_compare #(.LINE_W(LINE_W)) u_cmp (
    .clk(clk), .rst(rst), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .line(line), .adv(adv), .match_q(stat_match), .irq_q(irq_stat)
  );

  assign stat_line = line;

  // R1: clean state the cycle after reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (stat_line == '0 && !stat_match && !irq_stat));
endmodule

// File: tb/tb_scanline_counter.sv
`timescale 1ns/1ps
module tb_scanline_counter;
  localparam int DOTS  = 456;
  localparam int LINES = 154;
  localparam int NV    = 7;

  localparam int V_CMP  [NV] = '{1, 1, 5, 200, 153, 0, 0};
  localparam int V_N    [NV] = '{1, 1, 3, 10, 138, 1, 1};
  localparam int V_LINE [NV] = '{1, 2, 5, 15, 153, 0, 1};
  localparam int V_MAT  [NV] = '{1, 0, 1, 0, 1, 1, 0};

  logic       clk = 1'b0;
  logic       rst;
  logic       dot_tick;
  logic       cmp_we;
  logic [7:0] cmp_wdata;
  logic       stat_match;
  logic [7:0] stat_line;
  logic       irq_stat;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  scanline_counter dut (
    .clk(clk), .rst(rst), .dot_tick(dot_tick), .cmp_we(cmp_we),
    .cmp_wdata(cmp_wdata), .stat_match(stat_match), .stat_line(stat_line),
    .irq_stat(irq_stat)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      dot_tick = 1'b1;
      @(negedge clk);
      dot_tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic write_cmp(input int v);
    cmp_we    = 1'b1;
    cmp_wdata = 8'(v);
    @(negedge clk);
    cmp_we    = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int last_match;
    int prev;
    int exp_line;
    rst = 1'b1; dot_tick = 1'b0; cmp_we = 1'b0; cmp_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 line after reset", stat_line, 0);
    chk("R1 flag after reset", stat_match, 0);
    chk("R1 irq after reset", irq_stat, 0);
    rst = 1'b0;
    @(negedge clk);

    // vector table: compare value, lines to step, expected line and flag
    last_match = 0;
    exp_line   = 0;
    for (int v = 0; v < NV; v++) begin
      write_cmp(V_CMP[v]);
      if (V_N[v] > 1) begin
        run_ticks(DOTS * (V_N[v] - 1), 0);
        prev = (((exp_line + V_N[v] - 1) % LINES) == V_CMP[v]) ? 1 : 0;
      end else begin
        prev = last_match;
      end
      exp_line = (exp_line + V_N[v]) % LINES;
      run_ticks(DOTS, 0);
      chk("R2/R3 line after step", stat_line, V_LINE[v]);
      chk("R2/R3 model line", exp_line, V_LINE[v]);
      chk("R4 flag not yet updated", stat_match, prev);
      @(negedge clk);
      chk("R4/R5/R8 flag after compare", stat_match, V_MAT[v]);
      chk("R6 irq on matching step", irq_stat, V_MAT[v]);
      @(negedge clk);
      chk("R6 irq one cycle only", irq_stat, 0);
      chk("R5 flag held", stat_match, V_MAT[v]);
      last_match = V_MAT[v];
    end

    // R5: flag holds across idle cycles (line 1, flag 0)
    repeat (5) @(negedge clk);
    chk("R5 idle flag hold", stat_match, 0);
    // R7: writing current line does not re-evaluate
    write_cmp(1);
    repeat (3) begin
      chk("R7 flag after compare write", stat_match, 0);
      chk("R7 irq after compare write", irq_stat, 0);
      @(negedge clk);
    end
    // R2: ticks with gaps, then match on line 2 (R4)
    write_cmp(2);
    run_ticks(DOTS, 2);
    chk("R2 gapped ticks line", stat_line, 2);
    chk("R4 gapped flag", stat_match, 1);
    repeat (4) @(negedge clk);
    chk("R5 set flag held", stat_match, 1);

    // R1: reset in mid-line clears partial dot count
    run_ticks(200, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 line after mid reset", stat_line, 0);
    chk("R1 flag after mid reset", stat_match, 0);
    run_ticks(DOTS - 1, 1);
    chk("R1/R2 partial line no step", stat_line, 0);
    run_ticks(1, 0);
    chk("R2 step on last dot", stat_line, 1);
    @(negedge clk);
    chk("R1 compare reg cleared", stat_match, 0);
    chk("R1 no irq", irq_stat, 0);

    finish_run();
  end
endmodule